// File: doc/BRIEF.md
# Loop Boundary Rate Controller

This block controls one loop boundary in a dataflow circuit. On its slow side it sees one token per loop run. On its fast side it runs a parameterised number of iterations, `N`, for each slow token. It takes a slow-side operand, issues `N` iteration requests to the loop body, and collects `N` results. It then offers one slow-side result downstream. A modulo-`N` index output drives the select lines of the loop operators' multiplexers. A one-cycle load strobe tells the loop's registers when to capture a value. A flag marks the final iteration.

All four sides use a four-phase request/acknowledge protocol. A request stays high until its acknowledge arrives and is then dropped. The acknowledge is released after the request falls. To build nested loops, instances are chained: the fast side of an outer unit connects to the slow side of an inner unit. Where several producers or consumers share one input of this unit, their requests or acknowledges are ANDed together outside the unit. Acknowledges run in the opposite direction to their requests, between the same pair of units.

Top module: `loop_bound_ctrl`

## Requirements
- R1: While `rst` is high, on the clock edge after it rises, every request, acknowledge and strobe output is 0, `idx` is 0, and `at_last` equals (N == 1).
- R2: `idx` only takes values 0 to N-1. It advances by one after each completed fast-side result handshake, except after the final one. It stays unchanged while `it_req` is high.
- R3: `at_last` is 1 exactly when `idx` equals N-1.
- R4: `ld_en` is a one-cycle pulse. It rises together with `res_ack`, once per iteration, so each slow token gives exactly N pulses.
- R5: `it_req` rises only while `it_ack` is low. It stays high until `it_ack` is seen and then falls.
- R6: `res_ack` rises only when `res_req` is high. It stays high until `res_req` falls and then falls.
- R7: `out_req` rises only after the fast-side result handshake at `idx` = N-1 is complete. It never overlaps `it_req`. It stays high until `out_ack` is seen.
- R8: After the `out_req`/`out_ack` handshake completes, `idx` wraps to 0 and the unit can accept the next slow token.
- R9: `in_ack` rises on the edge where `it_ack` is first seen with `idx` = 0, which is when the first iteration has taken its operand. It stays high until `in_req` falls, and then it falls on the next edge.
- R10: An `in_req` raised while a loop run is still in progress does not start a new run. It is served only after the current run's `out_req`/`out_ack` handshake has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Slow-side upstream request: operand token available |
| in_ack | output | 1 | Slow-side upstream acknowledge |
| out_req | output | 1 | Slow-side downstream request: loop result available |
| out_ack | input | 1 | Slow-side downstream acknowledge (AND of consumers) |
| it_req | output | 1 | Fast-side downstream request: start iteration `idx` |
| it_ack | input | 1 | Fast-side downstream acknowledge (AND of consumers) |
| res_req | input | 1 | Fast-side upstream request: iteration result ready (AND of producers) |
| res_ack | output | 1 | Fast-side upstream acknowledge |
| idx | output | IW | Iteration index, used as the multiplexer select |
| at_last | output | 1 | High when `idx` is N-1 |
| ld_en | output | 1 | One-cycle register load strobe per iteration |

## Verification
The assertions assume that the neighbours obey the four-phase protocol. A neighbour keeps a request high until it sees the acknowledge. It raises an acknowledge only in answer to a request and holds it until that request falls. The fast-side producer returns a result only after its iteration has been started. The bench drives every input as such a neighbour would. It waits on each output level before it answers, and it varies the reply latency from zero to several cycles on each side. It also raises the next slow token early, while a run is still in progress.

// File: rtl/loop_bound_pkg.sv
package loop_bound_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ITREQ,
    ST_ITREL,
    ST_RESW,
    ST_RESACK,
    ST_OUTREQ,
    ST_OUTREL
  } lb_state_t;
endpackage

// File: rtl/lb_index_ctr.sv
module lb_index_ctr #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [IW-1:0] idx,
  output logic          at_last
);
  localparam logic [IW-1:0] TOP = IW'(N - 1);

  logic [IW-1:0] nxt;

  always_comb begin
    nxt = (idx == TOP) ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      at_last <= (N == 1);
    end else if (step) begin
      idx     <= nxt;
      at_last <= (nxt == TOP);
    end
  end

  p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
    idx <= TOP);
  p_last_match_r3: assert property (@(posedge clk) disable iff (rst)
    at_last == (idx == TOP));
  p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(idx) |-> (idx == $past(idx) + 1'b1) || (idx == '0));
endmodule

// File: rtl/lb_in_ack.sv
module lb_in_ack (
  input  logic clk,
  input  logic rst,
  input  logic in_req,
  input  logic take,
  output logic in_ack
);
  always_ff @(posedge clk) begin
    if (rst)
      in_ack <= 1'b0;
    else if (take)
      in_ack <= 1'b1;
    else if (in_ack && !in_req)
      in_ack <= 1'b0;
  end

  p_inack_hold_r9: assert property (@(posedge clk) disable iff (rst)
    in_ack && in_req |=> in_ack);
  p_inack_drop_r9: assert property (@(posedge clk) disable iff (rst)
    in_ack && !in_req && !take |=> !in_ack);
endmodule

// File: rtl/lb_sequencer.sv
module lb_sequencer
  import loop_bound_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_req,
  input  logic          in_ack,
  input  logic          out_ack,
  input  logic          it_ack,
  input  logic          res_req,
  input  logic [IW-1:0] idx,
  input  logic          at_last,
  output logic          out_req,
  output logic          it_req,
  output logic          res_ack,
  output logic          ld_en,
  output logic          step,
  output logic          take
);
  lb_state_t st;

  always_comb begin
    step = ((st == ST_RESACK) && !res_req && !at_last) ||
           ((st == ST_OUTREL) && !out_ack);
    take = (st == ST_ITREQ) && it_ack && (idx == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      it_req  <= 1'b0;
      res_ack <= 1'b0;
      out_req <= 1'b0;
      ld_en   <= 1'b0;
    end else begin
      ld_en <= 1'b0;
      unique case (st)
        ST_IDLE: if (in_req && !in_ack && !it_ack) begin
          it_req <= 1'b1;
          st     <= ST_ITREQ;
        end
        ST_ITREQ: if (it_ack) begin
          it_req <= 1'b0;
          st     <= ST_ITREL;
        end
        ST_ITREL: if (!it_ack) st <= ST_RESW;
        ST_RESW: if (res_req) begin
          res_ack <= 1'b1;
          ld_en   <= 1'b1;
          st      <= ST_RESACK;
        end
        ST_RESACK: if (!res_req) begin
          res_ack <= 1'b0;
          if (at_last) begin
            out_req <= 1'b1;
            st      <= ST_OUTREQ;
          end else begin
            it_req <= 1'b1;
            st     <= ST_ITREQ;
          end
        end
        ST_OUTREQ: if (out_ack) begin
          out_req <= 1'b0;
          st      <= ST_OUTREL;
        end
        ST_OUTREL: if (!out_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_itreq_hold_r5: assert property (@(posedge clk) disable iff (rst)
    it_req && !it_ack |=> it_req);
  p_itreq_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(it_req) |-> !$past(it_ack));
  p_idx_stable_r2: assert property (@(posedge clk) disable iff (rst)
    it_req && $past(it_req) |-> $stable(idx));
  p_resack_hold_r6: assert property (@(posedge clk) disable iff (rst)
    res_ack && res_req |=> res_ack);
  p_resack_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(res_ack) |-> $past(res_req));
  p_en_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> !ld_en);
  p_en_with_ack_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(res_ack) |-> ld_en);
  p_outreq_last_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_req) |-> at_last);
  p_outreq_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_req && !out_ack |=> out_req);
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
    !(out_req && it_req));
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(out_req) |-> at_last);
endmodule

// File: rtl/loop_bound_ctrl.sv
module loop_bound_ctrl #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_req,
  output logic          in_ack,
  output logic          out_req,
  input  logic          out_ack,
  output logic          it_req,
  input  logic          it_ack,
  input  logic          res_req,
  output logic          res_ack,
  output logic [IW-1:0] idx,
  output logic          at_last,
  output logic          ld_en
);
  logic step, take;

  lb_index_ctr #(.N(N), .IW(IW)) u_ctr (
    .clk(clk), .rst(rst), .step(step), .idx(idx), .at_last(at_last)
  );

  lb_in_ack u_inack (
    .clk(clk), .rst(rst), .in_req(in_req), .take(take), .in_ack(in_ack)
  );

  lb_sequencer #(.N(N), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .in_req(in_req), .in_ack(in_ack),
    .out_ack(out_ack), .it_ack(it_ack), .res_req(res_req),
    .idx(idx), .at_last(at_last), .out_req(out_req), .it_req(it_req),
    .res_ack(res_ack), .ld_en(ld_en), .step(step), .take(take)
  );

  p_inack_first_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> idx == '0 && $past(it_req && it_ack));
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !it_req && !out_req && !res_ack && !ld_en && !in_ack && idx == '0);
endmodule

// File: tb/sim_loop_bound_ctrl.sv
module sim_loop_bound_ctrl;
  localparam int N = 4;
  localparam int IW = $clog2(N);
  localparam time TCLK = 10ns;
  localparam int ROWS = 6;
  // {early next token, it_ack delay, res_req delay, out_ack delay}
  localparam logic [12:0] VEC [ROWS] = '{
    {1'b0, 4'd0, 4'd0, 4'd0},
    {1'b0, 4'd3, 4'd1, 4'd2},
    {1'b1, 4'd1, 4'd5, 4'd0},
    {1'b0, 4'd0, 4'd2, 4'd4},
    {1'b1, 4'd6, 4'd0, 4'd1},
    {1'b0, 4'd2, 4'd3, 4'd3}
  };

  logic clk = 0, rst = 1;
  logic in_req = 0, out_ack = 0, it_ack = 0, res_req = 0;
  logic in_ack, out_req, it_req, res_ack, at_last, ld_en;
  logic [IW-1:0] idx;
  int tests = 0, fails = 0, en_seen = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  loop_bound_ctrl #(.N(N)) u0 (
    .clk(clk), .rst(rst), .in_req(in_req), .in_ack(in_ack),
    .out_req(out_req), .out_ack(out_ack), .it_req(it_req), .it_ack(it_ack),
    .res_req(res_req), .res_ack(res_ack), .idx(idx), .at_last(at_last),
    .ld_en(ld_en)
  );

  always @(posedge clk) if (!rst && ld_en) en_seen++;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // 0:in_ack 1:out_req 2:it_req 3:res_ack
  function automatic logic pick(input int w);
    case (w)
      0: return in_ack;
      1: return out_req;
      2: return it_req;
      default: return res_ack;
    endcase
  endfunction

  task automatic wait_for(input int w, input logic lvl);
    @(negedge clk);
    while (pick(w) !== lvl) @(negedge clk);
  endtask

  task automatic run_token(input int dfd, input int dfu, input int dsd,
                           input bit skip_raise, input bit early);
    int e0;
    e0 = en_seen;
    if (!skip_raise) in_req = 1;
    for (int k = 0; k < N; k++) begin
      wait_for(2, 1);
      chk("R2 idx during it_req", idx, k);
      chk("R3 at_last", at_last, k == N - 1);
      chk("R7 no out_req mid-run", out_req, 0);
      if (k == 0) chk("R9 in_ack low before take", in_ack, 0);
      idle(dfd);
      chk("R5 it_req held", it_req, 1);
      it_ack = 1;
      wait_for(2, 0);
      it_ack = 0;
      if (k == 0) begin
        chk("R9 in_ack after first take", in_ack, 1);
        in_req = 0;
        wait_for(0, 0);
        if (early) in_req = 1;
      end
      idle(dfu);
      chk("R6 no res_ack before res_req", res_ack, 0);
      res_req = 1;
      wait_for(3, 1);
      res_req = 0;
      wait_for(3, 0);
    end
    wait_for(1, 1);
    chk("R7 out_req at last", at_last, 1);
    chk("R4 load pulses per token", en_seen - e0, N);
    idle(dsd);
    chk("R7 out_req held", out_req, 1);
    out_ack = 1;
    wait_for(1, 0);
    out_ack = 0;
    @(negedge clk);
    chk("R8 idx wraps", idx, 0);
    chk("R10 no restart before out handshake", it_req, 0);
  endtask

  initial begin
    bit pend;
    pend = 0;
    idle(2);
    chk("R1 reset it_req", it_req, 0);
    chk("R1 reset out_req", out_req, 0);
    chk("R1 reset in_ack", in_ack, 0);
    chk("R1 reset ld_en", ld_en, 0);
    chk("R1 reset idx", idx, 0);
    chk("R1 reset at_last", at_last, N == 1);
    rst = 0;
    idle(3);
    chk("R10 idle without in_req", it_req, 0);
    for (int r = 0; r < ROWS; r++) begin
      run_token(VEC[r][11:8], VEC[r][7:4], VEC[r][3:0], pend, VEC[r][12]);
      pend = VEC[r][12];
    end
    // mid-run reset
    in_req = 1;
    wait_for(2, 1);
    it_ack = 1; wait_for(2, 0); it_ack = 0;
    in_req = 0; wait_for(0, 0);
    res_req = 1; wait_for(3, 1); res_req = 0; wait_for(3, 0);
    wait_for(2, 1);
    chk("R2 idx second iter", idx, 1);
    rst = 1;
    idle(2);
    chk("R1 mid reset it_req", it_req, 0);
    chk("R1 mid reset idx", idx, 0);
    chk("R1 mid reset ld_en", ld_en, 0);
    rst = 0;
    idle(2);
    run_token(1, 1, 1, 0, 0);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule